// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the transmit half of a clocked synchronous serial channel. Software loads a byte into a holding register and then acknowledges the data-empty flag. The byte then moves into a shift register and leaves on the data pin one bit per serial clock period, least significant bit first. The serial clock comes from one of two sources. The first is an internal divider of the system clock, driven out on the clock pin only while a frame is moving. The second is an external clock input that passes through a synchronizer.

Three receive error flags (overrun, parity, framing) sit beside the transmit status flags. While any of them is set, no new frame may start. They stay set until software clears them, whether or not the receiver is enabled.

A single enable gates the transmitter. When the enable is dropped, any frame in progress is abandoned and the data pin returns to general-purpose port control, which lets software hold the line low as a break. In external clock mode, a clock edge that arrives too soon after a holding-register write is ignored and reported on a one-cycle pulse.

Top module: `sync_ser_tx`

## Requirements
- R1: A frame carries `tdr_data[0]` first and `tdr_data[7]` last, one bit for each serial clock rising edge. The bit is valid at the rising edge of `sck_out` (internal mode) or just before the rising edge of `sck_in` (external mode).
- R2: In internal mode, `sck_out` is low for `div_val+1` cycles and then high for `div_val+1` cycles for each bit, so one bit lasts `2*(div_val+1)` cycles. `sck_oe` is 1 only while a frame is shifting. `sck_out` rests at 1 when no frame is shifting.
- R3: `empty_flag` is 1 after reset. A pulse on `empty_clr` clears it. It is set again in the cycle the holding register moves into the shift register. A write without a clear never starts a frame.
- R4: `end_flag` is 1 after reset. It goes to 0 when a frame starts. It goes back to 1 after the last bit when `empty_flag` is 1.
- R5: `err_flags` bit 0 (overrun), bit 1 (parity) and bit 2 (framing) are set by their `rx_*_set` pulse only while `rx_en` is 1. No frame starts while any of these bits is 1, even with `empty_flag` cleared. A pending frame starts once all three are cleared.
- R6: Error bits keep their value when `rx_en` is 0. Only a 1 in the matching bit of `err_clr` clears a bit, and a clear pulse on a bit that is 0 changes nothing.
- R7: When `tx_en` is 0, the frame in progress is abandoned at once. `empty_flag` and `end_flag` are forced to 1, and `sck_oe` drops to 0.
- R8: With `tx_en` at 0, `txd` follows `port_dat` when `port_dir` is 1, and sits at 1 when `port_dir` is 0. With `tx_en` at 1 and no frame shifting, `txd` is 1 regardless of the port bits.
- R9: In external mode, every accepted rising edge of `sck_in` moves the frame one bit forward. `sck_oe` stays 0 and `sck_out` stays 1.
- R10: In external mode, a rising edge of `sck_in` that the synchronizer detects within 4 cycles of a `tdr_wr` is ignored, so it does not advance the frame, and `guard_hit` pulses. Edges detected 5 or more cycles after the write are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable, gates setting of error flags |
| ext_clk_sel | input | 1 | 1 selects the external serial clock |
| div_val | input | DIV_W | Half-bit length minus one, in system cycles, for internal mode |
| tdr_wr | input | 1 | Write strobe for the holding register |
| tdr_data | input | DATA_W | Byte written into the holding register |
| empty_clr | input | 1 | Clear strobe for the data-empty flag |
| rx_ovr_set | input | 1 | Receiver overrun indication |
| rx_par_set | input | 1 | Receiver parity error indication |
| rx_frm_set | input | 1 | Receiver framing error indication |
| err_clr | input | 3 | Per-bit clear for the error flags |
| port_dir | input | 1 | General-purpose port direction, 1 = output |
| port_dat | input | 1 | General-purpose port data |
| sck_in | input | 1 | External serial clock |
| txd | output | 1 | Serial data pin |
| sck_out | output | 1 | Internal serial clock output |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| empty_flag | output | 1 | Holding register is free |
| end_flag | output | 1 | Transmission finished with nothing pending |
| err_flags | output | 3 | Overrun, parity, framing error flags |
| guard_hit | output | 1 | Pulse: an external edge came too soon after a write |

## Verification
The assertions assume that `sck_in` rests high between frames and that its edges are several system cycles apart, so that the synchronizer sees every level. They also assume that `tx_en` and `ext_clk_sel` change only while no frame is in flight. The bench holds every external clock level for six cycles. It switches mode and enable only at frame boundaries, except in the deliberate abort case. It puts the one early edge right on a holding-register write, in the middle of a frame. Random bytes and random divider values cover the internal-clock path, and directed cases cover the error, abort, port and guard paths.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ERR_N   = 3;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  typedef logic [ERR_N-1:0] err_t;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int DIV_W     = 8,
  parameter int GUARD_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             busy,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             tdr_wr,
  input  logic             sck_in,
  output logic             bit_tick,
  output logic             phase,
  output logic             guard_hit
);
  localparam int AGE_W = $clog2(GUARD_CYC + 1);

  logic [DIV_W-1:0] cnt;
  logic [AGE_W-1:0] age;
  logic             s1, s2, s3;
  logic             rise, young, run_int;

  assign run_int = busy & tx_en & ~ext_sel;

  always_ff @(posedge clk) begin
    if (rst || !run_int) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == div_val) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= sck_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst)
      age <= AGE_W'(GUARD_CYC);
    else if (tdr_wr)
      age <= '0;
    else if (age != AGE_W'(GUARD_CYC))
      age <= age + 1'b1;
  end

  assign young = (age < AGE_W'(GUARD_CYC - 1));

  always_comb begin
    if (!(busy && tx_en))
      bit_tick = 1'b0;
    else if (ext_sel)
      bit_tick = rise & ~young;
    else
      bit_tick = phase & (cnt == div_val);
  end

  always_ff @(posedge clk) begin
    if (rst) guard_hit <= 1'b0;
    else     guard_hit <= tx_en & ext_sel & rise & young;
  end

  AST_GUARD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) (tdr_wr && ext_sel && tx_en) |=> !bit_tick); // R10
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              start,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              done,
  output logic              sdo
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      sreg <= '0;
    end else if (!tx_en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      sreg <= load_data;
    end else if (busy && bit_tick) begin
      if (cnt == CNT_W'(DATA_W - 1)) begin
        busy <= 1'b0;
      end else begin
        sreg <= sreg >> 1;
        cnt  <= cnt + 1'b1;
      end
    end
  end

  assign done = busy & bit_tick & (cnt == CNT_W'(DATA_W - 1));
  assign sdo  = sreg[0];

  AST_ABORT_NOW: assert property (@(posedge clk) disable iff (rst) !tx_en |=> !busy); // R7
endmodule

// File: rtl/sst_flags.sv
module sst_flags
  import sst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic rx_en,
  input  logic start,
  input  logic done,
  input  logic empty_clr,
  input  err_t err_set,
  input  err_t err_clr,
  output logic tdre,
  output logic tend,
  output err_t err
);
  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      tdre <= 1'b1;
      tend <= 1'b1;
    end else begin
      if (start)
        tdre <= 1'b1;
      else if (empty_clr && tdre)
        tdre <= 1'b0;
      if (start)
        tend <= 1'b0;
      else if (done)
        tend <= tdre;
    end
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)
        err[i] <= 1'b0;
      else if (rx_en && err_set[i])
        err[i] <= 1'b1;
      else if (err_clr[i])
        err[i] <= 1'b0;
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst) (!rx_en && err_clr == '0) |=> $stable(err)); // R6
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int GUARD_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              ext_clk_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tdr_wr,
  input  logic [DATA_W-1:0] tdr_data,
  input  logic              empty_clr,
  input  logic              rx_ovr_set,
  input  logic              rx_par_set,
  input  logic              rx_frm_set,
  input  logic [2:0]        err_clr,
  input  logic              port_dir,
  input  logic              port_dat,
  input  logic              sck_in,
  output logic              txd,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              empty_flag,
  output logic              end_flag,
  output logic [2:0]        err_flags,
  output logic              guard_hit
);
  logic [DATA_W-1:0] tdr;
  logic busy, done, sdo, bit_tick, phase, start;
  logic tdre, tend;
  err_t err_q, err_set;

  always_ff @(posedge clk) begin
    if (rst)         tdr <= '0;
    else if (tdr_wr) tdr <= tdr_data;
  end

  assign start = tx_en & ~busy & ~tdre & (err_q == '0);

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = rx_ovr_set;
    err_set[ERR_PAR] = rx_par_set;
    err_set[ERR_FRM] = rx_frm_set;
  end

  sst_clkgen #(.DIV_W(DIV_W), .GUARD_CYC(GUARD_CYC)) u_clk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .busy(busy), .ext_sel(ext_clk_sel),
    .div_val(div_val), .tdr_wr(tdr_wr), .sck_in(sck_in),
    .bit_tick(bit_tick), .phase(phase), .guard_hit(guard_hit)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst(rst), .tx_en(tx_en), .start(start), .bit_tick(bit_tick),
    .load_data(tdr), .busy(busy), .done(done), .sdo(sdo)
  );

  sst_flags u_flg (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .start(start),
    .done(done), .empty_clr(empty_clr), .err_set(err_set), .err_clr(err_clr),
    .tdre(tdre), .tend(tend), .err(err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd     <= 1'b1;
      sck_out <= 1'b1;
      sck_oe  <= 1'b0;
    end else begin
      if (!tx_en)    txd <= port_dir ? port_dat : 1'b1;
      else if (busy) txd <= sdo;
      else           txd <= 1'b1;
      sck_out <= (busy && tx_en && !ext_clk_sel) ? phase : 1'b1;
      sck_oe  <= busy & tx_en & ~ext_clk_sel;
    end
  end

  assign empty_flag = tdre;
  assign end_flag   = tend;
  assign err_flags  = err_q;

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(err_q == '0)); // R5
  AST_TDRE_ON_LOAD: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> tdre); // R3
  AST_TEND_IDLE: assert property (@(posedge clk) disable iff (rst) tend |-> !busy); // R4
  AST_EXT_NO_SCK: assert property (@(posedge clk) disable iff (rst) (ext_clk_sel && $past(ext_clk_sel)) |-> (!sck_oe && sck_out)); // R9
endmodule

// File: tb/sync_ser_tx_tb.sv
module sync_ser_tx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, rx_en = 1'b0, ext_clk_sel = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic tdr_wr = 1'b0;
  logic [7:0] tdr_data = 8'd0;
  logic empty_clr = 1'b0, rx_ovr_set = 1'b0, rx_par_set = 1'b0, rx_frm_set = 1'b0;
  logic [2:0] err_clr = 3'b0;
  logic port_dir = 1'b0, port_dat = 1'b0, sck_in = 1'b1;
  logic txd, sck_out, sck_oe, empty_flag, end_flag, guard_hit;
  logic [2:0] err_flags;

  int checks = 0, fails = 0, ncap = 0, period_bad = 0, gap = 0, exp_period = 2, gh_cnt = 0;
  logic [7:0] cap = 8'd0;
  logic sck_prev = 1'b1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_ser_tx u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .ext_clk_sel(ext_clk_sel),
    .div_val(div_val), .tdr_wr(tdr_wr), .tdr_data(tdr_data), .empty_clr(empty_clr),
    .rx_ovr_set(rx_ovr_set), .rx_par_set(rx_par_set), .rx_frm_set(rx_frm_set),
    .err_clr(err_clr), .port_dir(port_dir), .port_dat(port_dat), .sck_in(sck_in),
    .txd(txd), .sck_out(sck_out), .sck_oe(sck_oe), .empty_flag(empty_flag),
    .end_flag(end_flag), .err_flags(err_flags), .guard_hit(guard_hit)
  );

  always @(negedge clk) begin
    gap = gap + 1;
    if (guard_hit) gh_cnt = gh_cnt + 1;
    if (sck_out && !sck_prev && sck_oe) begin
      if (ncap > 0 && gap != exp_period) period_bad = period_bad + 1;
      cap  = {txd, cap[7:1]};
      ncap = ncap + 1;
      gap  = 0;
    end
    sck_prev = sck_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tdr(input logic [7:0] d);
    tdr_data = d; tdr_wr = 1'b1; cyc(1); tdr_wr = 1'b0;
  endtask

  task automatic clear_empty();
    empty_clr = 1'b1; cyc(1); empty_clr = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 60 && end_flag; i++) cyc(1);
    for (int i = 0; i < 3000 && !end_flag; i++) cyc(1);
  endtask

  function automatic int bit_len(input int d);
    return 2 * (d + 1);
  endfunction

  task automatic int_frame(input logic [7:0] d, input int dv);
    div_val = 8'(dv); exp_period = bit_len(dv);
    ncap = 0; cap = 0; period_bad = 0;
    write_tdr(d);
    clear_empty();
    wait_end();
    cyc(2);
    chk(cap == d, "R1 frame bits", cap, d);
    chk(ncap == 8 && period_bad == 0, "R2 bit count and sck period", ncap * 256 + period_bad, 8 * 256);
    chk(end_flag && empty_flag, "R4 end flag after frame", {end_flag, empty_flag}, 2'b11);
    chk(sck_out && !sck_oe && txd, "R2 idle clock and R8 idle data", {sck_out, sck_oe, txd}, 3'b101);
  endtask

  task automatic ext_edge(output logic b);
    sck_in = 1'b0; cyc(6);
    b = txd;
    sck_in = 1'b1; cyc(6);
  endtask

  initial begin
    logic [7:0] d, ecap;
    logic b;
    void'($urandom(32'h5A17));
    cyc(5);
    rst = 1'b0;
    cyc(2);
    chk(empty_flag == 1'b1, "R3 reset empty", empty_flag, 1);
    chk(end_flag == 1'b1, "R4 reset end", end_flag, 1);
    chk(err_flags == 3'b000, "R5 reset errors", err_flags, 0);
    chk(txd && !sck_oe && sck_out, "R8 reset pins", {txd, sck_oe, sck_out}, 3'b101);

    tx_en = 1'b1; rx_en = 1'b1;
    port_dir = 1'b1; port_dat = 1'b0;
    cyc(2);
    chk(txd == 1'b1, "R8 enabled idle ignores port", txd, 1);

    ncap = 0;
    write_tdr(8'h3C);
    cyc(20);
    chk(empty_flag && ncap == 0 && end_flag, "R3 write without clear does not start", {empty_flag, end_flag, 8'(ncap)}, 10'h300);

    int_frame(8'h01, 0);
    int_frame(8'h80, 3);
    int_frame(8'hA5, 1);
    for (int k = 0; k < 10; k++) int_frame(8'($urandom), int'($urandom % 4));

    // error flags block start (R5), hold with rx disabled (R6)
    rx_par_set = 1'b1; cyc(1); rx_par_set = 1'b0; cyc(1);
    chk(err_flags == 3'b010, "R5 parity flag set", err_flags, 3'b010);
    div_val = 8'd1; exp_period = 4; ncap = 0; cap = 0; period_bad = 0;
    write_tdr(8'h6B);
    clear_empty();
    cyc(30);
    chk(!empty_flag && ncap == 0 && !sck_oe, "R5 start blocked by error", {empty_flag, 8'(ncap)}, 0);
    rx_en = 1'b0; cyc(5);
    chk(err_flags == 3'b010, "R6 flags kept with rx disabled", err_flags, 3'b010);
    rx_ovr_set = 1'b1; cyc(1); rx_ovr_set = 1'b0; cyc(1);
    chk(err_flags == 3'b010, "R5 no set while rx disabled", err_flags, 3'b010);
    err_clr = 3'b001; cyc(1); err_clr = 3'b000; cyc(1);
    chk(err_flags == 3'b010, "R6 clear of zero bit no effect", err_flags, 3'b010);
    err_clr = 3'b010; cyc(1); err_clr = 3'b000;
    wait_end();
    cyc(2);
    chk(err_flags == 3'b000, "R6 explicit clear", err_flags, 0);
    chk(cap == 8'h6B && ncap == 8, "R5 pending frame after clear", cap, 8'h6B);
    rx_en = 1'b1;
    rx_frm_set = 1'b1; cyc(1); rx_frm_set = 1'b0; cyc(1);
    chk(err_flags == 3'b100, "R5 framing flag set", err_flags, 3'b100);
    err_clr = 3'b100; cyc(1); err_clr = 3'b000; cyc(1);

    // abort (R7) and port mux / break (R8)
    div_val = 8'd3; exp_period = 8;
    write_tdr(8'hF0);
    clear_empty();
    cyc(20);
    chk(sck_oe == 1'b1, "R2 sck driven while shifting", sck_oe, 1);
    port_dir = 1'b1; port_dat = 1'b0;
    tx_en = 1'b0;
    cyc(2);
    chk(empty_flag && end_flag && !sck_oe, "R7 abort state", {empty_flag, end_flag, sck_oe}, 3'b110);
    chk(txd == 1'b0, "R8 break level", txd, 0);
    port_dat = 1'b1; cyc(2);
    chk(txd == 1'b1, "R8 port data high", txd, 1);
    port_dir = 1'b0; port_dat = 1'b0; cyc(2);
    chk(txd == 1'b1, "R8 port released", txd, 1);
    ncap = 0;
    tx_en = 1'b1; cyc(20);
    chk(ncap == 0 && empty_flag, "R7 no resume after re-enable", ncap, 0);

    // external clock (R9), guard (R10)
    ext_clk_sel = 1'b1;
    for (int k = 0; k < 4; k++) begin
      d = (k == 0) ? 8'hC3 : 8'($urandom);
      write_tdr(d);
      clear_empty();
      cyc(10);
      ecap = 0;
      for (int i = 0; i < 8; i++) begin
        ext_edge(b);
        ecap = {b, ecap[7:1]};
      end
      cyc(4);
      chk(ecap == d, "R9 external frame bits", ecap, d);
      chk(end_flag && !sck_oe && sck_out, "R9 end and no clock drive", {end_flag, sck_oe, sck_out}, 3'b101);
    end

    d = 8'h5D; gh_cnt = 0;
    write_tdr(d);
    clear_empty();
    cyc(10);
    ecap = 0;
    for (int i = 0; i < 3; i++) begin
      ext_edge(b);
      ecap = {b, ecap[7:1]};
    end
    sck_in = 1'b0; cyc(6);
    tdr_data = 8'h99; tdr_wr = 1'b1; sck_in = 1'b1;
    cyc(1); tdr_wr = 1'b0;
    cyc(6);
    chk(gh_cnt == 1, "R10 guard pulse", gh_cnt, 1);
    chk(txd == d[3], "R10 early edge ignored", txd, d[3]);
    for (int i = 3; i < 8; i++) begin
      ext_edge(b);
      ecap = {b, ecap[7:1]};
    end
    cyc(4);
    chk(ecap == d, "R10 frame intact after early edge", ecap, d);
    chk(end_flag == 1'b1, "R4 end after guarded frame", end_flag, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule